// File: doc/BRIEF.md
# Down-Counting Interval Timer with 16-bit Register Access

This block is a 32-bit timer that counts down once per clock. A processor programs it through six 16-bit registers on a simple single-cycle bus. Software loads a period as two halves and starts or halts the count with self-clearing command bits. It picks one-shot or auto-reload behaviour and masks or unmasks the interrupt line.

Every timeout sets a sticky flag. Any write to the status register clears that flag. A loaded period P gives a timeout every P+1 cycles. The count is wider than one register, so software must not read it directly. It writes the low snapshot register instead, which freezes the whole live count in one cycle, and then reads the two frozen halves at leisure.

Reads are combinational from the address. Writes take effect at the clock edge on which `bus_sel_i` and `bus_we_i` are both high.

Top module: `ivt_top`

## Requirements
- R1: After reset the counter is halted, status and control read 0, both period halves and both snapshot halves read 0xFFFF, and `irq_o` is low.
- R2: Registers sit at byte offsets 0 (status), 4 (control), 8 (period bits 15:0), 12 (period bits 31:16), 16 (snapshot bits 15:0) and 20 (snapshot bits 31:16). Control bit 0 is the interrupt enable, bit 1 the auto-reload select, bit 2 the start command and bit 3 the halt command. Only bits 1:0 are stored; bits 3:2 read back as 0. Status bit 0 is the timeout flag and status bit 1 reads 1 while counting.
- R3: In one-shot mode, after a write with the start bit set on clock edge E, the timeout flag rises on edge E+P+1. On that edge the counter halts and reloads P.
- R4: In auto-reload mode, the counter reloads P at every timeout and keeps running, so timeouts are P+1 cycles apart.
- R5: A control write with the halt bit set stops the counter. This holds even when the start bit is set in the same write.
- R6: A write to either period register halts the counter and loads it with the full new period.
- R7: Any write to offset 16 captures the whole 32-bit count in that cycle. Both snapshot halves then return the captured value until the next capture.
- R8: Any write to the status register clears the timeout flag, unless a timeout happens on the same edge.
- R9: `irq_o` is high exactly when the timeout flag and the interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from the address |
| irq_o | output | 1 | Timeout interrupt |

## Verification
The hardest case to reach is a snapshot taken while the count is moving. The bench needs a count whose upper half is nonzero, and a capture at a known edge relative to the start. It loads a period above 0x30000, records the exact start and capture edges, and derives the expected frozen value from their distance. It then reads the halves many cycles later, after the live count has changed. It measures timeout spacing from the edge of the start write to the rising edge of the interrupt. The status clear between two timeouts is placed so that it never coincides with a reload.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // word index = byte offset >> 2
  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_CTRL   = 1;
  localparam int unsigned IDX_PER    = 2;
  localparam int unsigned IDX_SNAP   = 4;

  localparam int unsigned C_IEN   = 0;
  localparam int unsigned C_AUTO  = 1;
  localparam int unsigned C_GO    = 2;
  localparam int unsigned C_HALT  = 3;

  localparam int unsigned S_TO  = 0;
  localparam int unsigned S_RUN = 1;

  typedef struct packed {
    logic auto_rl;
    logic ien;
  } ctrl_t;
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              run_i,
  input  logic              to_i,
  input  logic [CNT_W-1:0]  snap_i,
  output logic [REG_W-1:0]  rdata_o,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  period_o,
  output logic [CNT_W-1:0]  period_nxt_o,
  output logic              wr_status_o,
  output logic              wr_period_o,
  output logic              go_o,
  output logic              halt_o,
  output logic              capture_o
);
  localparam int unsigned NHALF = CNT_W / REG_W;
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr, wr_ctrl;
  logic [NHALF-1:0] per_hit;
  logic [REG_W-1:0] per_rd  [NHALF];
  logic [REG_W-1:0] snap_rd [NHALF];
  ctrl_t            ctrl_q;

  assign idx         = addr_i[ADDR_W-1:2];
  assign wr          = sel_i & we_i;
  assign wr_ctrl     = wr && (idx == IDX_W'(IDX_CTRL));
  assign wr_status_o = wr && (idx == IDX_W'(IDX_STATUS));
  assign capture_o   = wr && (idx == IDX_W'(IDX_SNAP));
  assign go_o        = wr_ctrl & wdata_i[C_GO];
  assign halt_o      = wr_ctrl & wdata_i[C_HALT];
  assign wr_period_o = |per_hit;
  assign ctrl_o      = ctrl_q;

  for (genvar i = 0; i < NHALF; i++) begin : g_half
    logic [REG_W-1:0] per_q;
    assign per_hit[i] = wr && (idx == IDX_W'(IDX_PER + i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         per_q <= '1;
      else if (per_hit[i]) per_q <= wdata_i;
    end
    assign per_rd[i]                          = per_q;
    assign snap_rd[i]                         = snap_i[i*REG_W +: REG_W];
    assign period_o[i*REG_W +: REG_W]         = per_q;
    assign period_nxt_o[i*REG_W +: REG_W]     = per_hit[i] ? wdata_i : per_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.ien     <= wdata_i[C_IEN];
      ctrl_q.auto_rl <= wdata_i[C_AUTO];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (idx == IDX_W'(IDX_STATUS)) begin
      rdata_o[S_TO]  = to_i;
      rdata_o[S_RUN] = run_i;
    end
    if (idx == IDX_W'(IDX_CTRL)) begin
      rdata_o[C_IEN]  = ctrl_q.ien;
      rdata_o[C_AUTO] = ctrl_q.auto_rl;
    end
    for (int i = 0; i < NHALF; i++) begin
      if (idx == IDX_W'(IDX_PER + i))  rdata_o = per_rd[i];
      if (idx == IDX_W'(IDX_SNAP + i)) rdata_o = snap_rd[i];
    end
  end
endmodule

// File: rtl/ivt_count.sv
module ivt_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] period_nxt_i,
  input  logic             auto_rl_i,
  input  logic             go_i,
  input  logic             halt_i,
  input  logic             wr_period_i,
  input  logic             clr_to_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             to_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, to_q, fire;

  // a command on the same edge pre-empts the timeout
  assign fire = run_q && (cnt_q == '0) && !wr_period_i && !halt_i && !go_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      run_q <= 1'b0;
    end else if (wr_period_i) begin
      cnt_q <= period_nxt_i;
      run_q <= 1'b0;
    end else if (halt_i) begin
      run_q <= 1'b0;
    end else if (go_i) begin
      run_q <= 1'b1;
    end else if (fire) begin
      cnt_q <= period_i;
      run_q <= auto_rl_i;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // a new timeout beats a clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       to_q <= 1'b0;
    else if (fire)     to_q <= 1'b1;
    else if (clr_to_i) to_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
  assign to_o  = to_q;
endmodule

// File: rtl/ivt_snap.sv
module ivt_snap #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] snap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_o <= '1;
    else if (capture_i) snap_o <= cnt_i;
  end
endmodule

// File: rtl/ivt_top.sv
module ivt_top
  import ivt_pkg::*;
#(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned CNT_W  = 2 * REG_W,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] period_q, period_nxt, cnt_q, snap_q;
  logic             run_q, to_q;
  logic             wr_status, wr_period, go, halt, capture;

  ivt_regs #(.REG_W(REG_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_i        (bus_sel_i),
    .we_i         (bus_we_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .run_i        (run_q),
    .to_i         (to_q),
    .snap_i       (snap_q),
    .rdata_o      (bus_rdata_o),
    .ctrl_o       (ctrl_q),
    .period_o     (period_q),
    .period_nxt_o (period_nxt),
    .wr_status_o  (wr_status),
    .wr_period_o  (wr_period),
    .go_o         (go),
    .halt_o       (halt),
    .capture_o    (capture)
  );

  ivt_count #(.CNT_W(CNT_W)) u_count (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .period_i     (period_q),
    .period_nxt_i (period_nxt),
    .auto_rl_i    (ctrl_q.auto_rl),
    .go_i         (go),
    .halt_i       (halt),
    .wr_period_i  (wr_period),
    .clr_to_i     (wr_status),
    .cnt_o        (cnt_q),
    .run_o        (run_q),
    .to_o         (to_q)
  );

  ivt_snap #(.CNT_W(CNT_W)) u_snap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .cnt_i     (cnt_q),
    .snap_o    (snap_q)
  );

  assign irq_o = to_q & ctrl_q.ien;
endmodule

// File: rtl/ivt_chk.sv
module ivt_chk #(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic              run_i,
  input logic              to_i,
  input logic              auto_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  period_i,
  input logic [CNT_W-1:0]  snap_i
);
  logic             wr;
  logic [ADDR_W-3:0] idx;
  assign wr  = sel_i & we_i;
  assign idx = addr_i[ADDR_W-1:2];

  // R3
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && (cnt_i != '0) && !wr |=> cnt_i == CNT_W'($past(cnt_i) - 1'b1));

  // R3
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && (cnt_i == '0) && !wr && !auto_i |=> !run_i && to_i);

  // R4
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && (cnt_i == '0) && !wr && auto_i |=> run_i && to_i && (cnt_i == period_i));

  // R5
  halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && (idx == 1) && wdata_i[3] |=> !run_i);

  // R6
  period_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && ((idx == 2) || (idx == 3)) |=> !run_i && (cnt_i == period_i));

  // R7
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && (idx == 4) |=> snap_i == $past(cnt_i));

  // R8
  status_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && (idx == 0) && !(run_i && cnt_i == '0) |=> !to_i);
endmodule

bind ivt_top ivt_chk #(.REG_W(REG_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (bus_sel_i),
  .we_i     (bus_we_i),
  .addr_i   (bus_addr_i),
  .wdata_i  (bus_wdata_i),
  .run_i    (run_q),
  .to_i     (to_q),
  .auto_i   (ctrl_q.auto_rl),
  .cnt_i    (cnt_q),
  .period_i (period_q),
  .snap_i   (snap_q)
);

// File: tb/ivt_tb.sv
`timescale 1ns/1ps
module ivt_top_tb_top;
  localparam logic [4:0] A_STAT = 5'd0, A_CTRL = 5'd4, A_PL = 5'd8,
                         A_PH = 5'd12, A_SL = 5'd16, A_SH = 5'd20;
  // {period, expected start-to-timeout cycles}
  localparam logic [63:0] ONESHOT_VEC [4] = '{
    {32'd0,  32'd1}, {32'd1, 32'd2}, {32'd5, 32'd6}, {32'd37, 32'd38}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [4:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        irq_o;

  int cyc = 0, wr_cyc = 0, rise_cyc = 0, rise_cnt = 0;
  int checks = 0, errors = 0;
  logic irq_prev = 1'b0;

  ivt_top dut_i (.*);

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;
  always @(negedge clk_i) begin
    if (irq_o && !irq_prev) begin rise_cyc = cyc; rise_cnt++; end
    irq_prev = irq_o;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0;
    wr_cyc = cyc;
  endtask

  task automatic bus_rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    bus_sel_i = 1'b0;
  endtask

  task automatic set_period(logic [31:0] p);
    bus_wr(A_PL, p[15:0]);
    bus_wr(A_PH, p[31:16]);
  endtask

  task automatic wait_rise(int n0, int limit);
    int k = 0;
    while (rise_cnt == n0 && k < limit) begin
      @(negedge clk_i); #2; k++;
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [15:0] d, hi, lo;
    logic [31:0] p, exp_snap;
    int n0, r1, s0;

    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    bus_rd(A_STAT, d); check("R1 status", d, 0);
    bus_rd(A_CTRL, d); check("R1 ctrl", d, 0);
    bus_rd(A_PL, d);   check("R1 period lo", d, 16'hFFFF);
    bus_rd(A_PH, d);   check("R1 period hi", d, 16'hFFFF);
    bus_rd(A_SL, d);   check("R1 snap lo", d, 16'hFFFF);
    bus_rd(A_SH, d);   check("R1 snap hi", d, 16'hFFFF);
    check("R1 irq", irq_o, 0);

    // R3 one-shot table
    foreach (ONESHOT_VEC[v]) begin
      p = ONESHOT_VEC[v][63:32];
      set_period(p);
      n0 = rise_cnt;
      bus_wr(A_CTRL, 16'h0005);
      s0 = wr_cyc;
      wait_rise(n0, 200);
      check("R3 one-shot delay", rise_cyc - s0, ONESHOT_VEC[v][31:0]);
      bus_rd(A_STAT, d); check("R3 halted with flag", d, 16'h0001);
      bus_wr(A_STAT, 16'h0000);
      check("R8 irq cleared", irq_o, 0);
      bus_rd(A_STAT, d); check("R8 status cleared", d, 0);
    end

    // R4 auto-reload spacing
    set_period(32'd9);
    n0 = rise_cnt;
    bus_wr(A_CTRL, 16'h0007);
    wait_rise(n0, 200);
    r1 = rise_cyc;
    bus_wr(A_STAT, 16'h0000);
    n0 = rise_cnt;
    wait_rise(n0, 200);
    check("R4 reload spacing", rise_cyc - r1, 10);
    bus_rd(A_STAT, d); check("R4 still running", d, 16'h0003);

    // R5 halt wins over start; R2 readback
    bus_wr(A_CTRL, 16'h000F);
    bus_rd(A_STAT, d); check("R5 halted", d[1], 0);
    bus_rd(A_CTRL, d); check("R2 ctrl readback", d, 16'h0003);
    bus_wr(A_STAT, 16'h0000);

    // R9 masking
    set_period(32'd3);
    bus_wr(A_CTRL, 16'h0006);
    repeat (12) @(negedge clk_i);
    check("R9 irq masked", irq_o, 0);
    bus_rd(A_STAT, d); check("R9 flag set while masked", d[0], 1);
    bus_wr(A_CTRL, 16'h0001);
    check("R9 irq unmasked", irq_o, 1);
    bus_wr(A_CTRL, 16'h0009);
    bus_wr(A_STAT, 16'h0000);
    check("R8 irq low after clear", irq_o, 0);

    // R6 period write halts and reloads
    set_period(32'd1000);
    bus_wr(A_CTRL, 16'h0006);
    repeat (5) @(negedge clk_i);
    bus_wr(A_PL, 16'd1000);
    bus_rd(A_STAT, d); check("R6 halted by period write", d[1], 0);
    bus_wr(A_SL, 16'h0000);
    bus_rd(A_SH, hi); bus_rd(A_SL, lo);
    check("R6 count reloaded", {hi, lo}, 32'd1000);

    // R7 coherent snapshot while counting
    p = 32'h0003_0010;
    set_period(p);
    bus_wr(A_CTRL, 16'h0006);
    s0 = wr_cyc;
    repeat (7) @(negedge clk_i);
    bus_wr(A_SL, 16'h1234);
    exp_snap = p - 32'(wr_cyc - s0 - 1);
    repeat (20) @(negedge clk_i);
    bus_rd(A_SH, hi); bus_rd(A_SL, lo);
    check("R7 snapshot value", {hi, lo}, exp_snap);
    repeat (30) @(negedge clk_i);
    bus_rd(A_SL, lo);
    check("R7 snapshot frozen", lo, exp_snap[15:0]);
    bus_rd(A_STAT, d); check("R2 run bit", d, 16'h0002);

    report();
  end
endmodule